// File: doc/BRIEF.md
# Accumulator ALU with Bitwise Operations

This block is the arithmetic and logic datapath of a small accumulator CPU. It holds two registers: an accumulator A and an operand register B. Both can be loaded from a shared data bus. Five operation control lines are provided: subtract, add, AND, OR and NOT. Each line is driven by one bit of a microcode word. On a rising clock edge the selected operation is applied, and its result is written back into A. NOT inverts A and does not use B. The value of A is always visible on `acc_out`. It is also placed on `bus_out` while the bus-drive enable is high.

The design is organised around a registered state (A, B) and a decoded operation kind. The decoded kind is an enumeration with these values:
- `OP_IDLE`: no operation line is active.
- `OP_SUB`: subtract.
- `OP_ADD`: add.
- `OP_AND`: bitwise AND.
- `OP_OR`: bitwise OR.
- `OP_NOT`: bitwise NOT.

The kind is chosen by a fixed priority. The state register process has these transitions:
- Reset clears A and B.
- Any non-idle kind writes the computed result into A.
- `OP_IDLE` together with `load_a` copies the bus into A.
- `OP_IDLE` without `load_a` holds A.
- `load_b` copies the bus into B on any edge.

A separate output process forms `acc_out` and `bus_out`.

Top module: `acc_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears A and B to 0. After reset `acc_out` reads 0, and an add with a freshly loaded A returns A unchanged.
- R2: With no operation line active, `load_a` high copies `bus_in` into A at the rising edge. `load_b` high copies `bus_in` into B.
- R3: `op_add` alone sets A to (A + B) modulo 256.
- R4: `op_sub` alone sets A to the two's-complement difference (A − B) modulo 256.
- R5: `op_and` alone sets A to A & B.
- R6: `op_or` alone sets A to A | B.
- R7: `op_not` alone sets A to ~A. The value of B has no effect on the result.
- R8: When no operation line and no `load_a` is active, A keeps its value across edges.
- R9: When several operation lines are active, the highest-ranked one is applied. The ranking from highest to lowest is: subtract, add, AND, OR, NOT. Any active operation line takes precedence over `load_a`.
- R10: `bus_out` equals A while `drive_a` is high and is 0 while it is low.
- R11: When `load_b` and an operation are active on the same edge, the operation uses the B value held before that edge. The new B is used from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 8 | Shared data bus into the block |
| load_a | input | 1 | Copy bus into A when no operation is active |
| load_b | input | 1 | Copy bus into B |
| op_sub | input | 1 | Subtract control line |
| op_add | input | 1 | Add control line |
| op_and | input | 1 | AND control line |
| op_or | input | 1 | OR control line |
| op_not | input | 1 | NOT control line |
| drive_a | input | 1 | Place A onto bus_out |
| acc_out | output | 8 | Current value of A |
| bus_out | output | 8 | A when drive_a is high, else 0 |

## Verification
Each operation or load is captured at the rising edge where its control line is high, and `acc_out` shows the new A one edge later with no further latency. `bus_out` follows `drive_a` and A with no register in between. The bench changes inputs just after a falling edge and samples results at the following falling edge, which lies exactly one rising edge after the stimulus. Multi-cycle cases, namely the hold test and the stale-B test, advance one edge per step and check after each one.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADD  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_NOT  = 3'd5
    } op_kind_t;

    localparam int NUM_OP_LINES = 5;

endpackage

// File: rtl/acc_alu_decode.sv
// Priority encoder from the five operation control lines to one operation kind.
// Bit order of op_lines: [4]=sub, [3]=add, [2]=and, [1]=or, [0]=not.
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [NUM_OP_LINES-1:0] op_lines,
    output op_kind_t                kind
);

    always_comb begin
        // R9: subtract outranks add, add outranks AND, AND outranks OR, OR outranks NOT
        if (op_lines[4])      kind = OP_SUB;
        else if (op_lines[3]) kind = OP_ADD;
        else if (op_lines[2]) kind = OP_AND;
        else if (op_lines[1]) kind = OP_OR;
        else if (op_lines[0]) kind = OP_NOT;
        else                  kind = OP_IDLE;
    end

endmodule

// File: rtl/acc_alu_compute.sv
// Combinational result generator for the selected operation kind.
module acc_alu_compute
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_kind_t         kind,
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    output logic [WIDTH-1:0] result
);

    always_comb begin
        unique case (kind)
            OP_SUB:  result = a_val - b_val;  // R4: wraps modulo 2**WIDTH
            OP_ADD:  result = a_val + b_val;  // R3
            OP_AND:  result = a_val & b_val;  // R5
            OP_OR:   result = a_val | b_val;  // R6
            OP_NOT:  result = ~a_val;         // R7: b_val not used
            OP_IDLE: result = a_val;
            default: result = a_val;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             load_a,
    input  logic             load_b,
    input  logic             op_sub,
    input  logic             op_add,
    input  logic             op_and,
    input  logic             op_or,
    input  logic             op_not,
    input  logic             drive_a,
    output logic [WIDTH-1:0] acc_out,
    output logic [WIDTH-1:0] bus_out
);

    logic [WIDTH-1:0]        a_q;
    logic [WIDTH-1:0]        b_q;
    logic [WIDTH-1:0]        alu_result;
    logic [NUM_OP_LINES-1:0] op_lines;
    op_kind_t                kind;

    assign op_lines = {op_sub, op_add, op_and, op_or, op_not};

    acc_alu_decode u_decode (
        .op_lines (op_lines),
        .kind     (kind)
    );

    acc_alu_compute #(.WIDTH(WIDTH)) u_compute (
        .kind   (kind),
        .a_val  (a_q),
        .b_val  (b_q),
        .result (alu_result)
    );

    // State register process: A and B
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;                        // R1
            b_q <= '0;
        end else begin
            unique case (kind)
                OP_IDLE: if (load_a) a_q <= bus_in;   // R2, R8
                default: a_q <= alu_result;           // R9: op beats load_a
            endcase
            if (load_b) b_q <= bus_in;                // R2, R11
        end
    end

    // Output process
    always_comb begin
        acc_out = a_q;
        bus_out = drive_a ? a_q : '0;                 // R10
    end

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] bus_in,
    input logic             load_a,
    input logic             op_sub,
    input logic             op_add,
    input logic             op_and,
    input logic             op_or,
    input logic             op_not,
    input logic [WIDTH-1:0] acc_out,
    input logic [WIDTH-1:0] b_q
);

    logic any_op;
    assign any_op = op_sub | op_add | op_and | op_or | op_not;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && b_q == '0));

    assert_load_a_R2: assert property (@(posedge clk) disable iff (rst)
        (load_a && !any_op) |=> (acc_out == $past(bus_in)));

    assert_sub_result_R4: assert property (@(posedge clk) disable iff (rst)
        op_sub |=> (acc_out == WIDTH'($past(acc_out) - $past(b_q))));

    assert_not_result_R7: assert property (@(posedge clk) disable iff (rst)
        (op_not && !op_sub && !op_add && !op_and && !op_or)
            |=> (acc_out == ~$past(acc_out)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!any_op && !load_a) |=> $stable(acc_out));

endmodule

bind acc_alu acc_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_in  (bus_in),
    .load_a  (load_a),
    .op_sub  (op_sub),
    .op_add  (op_add),
    .op_and  (op_and),
    .op_or   (op_or),
    .op_not  (op_not),
    .acc_out (acc_out),
    .b_q     (b_q)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_in;
    logic       load_a, load_b;
    logic       op_sub, op_add, op_and, op_or, op_not;
    logic       drive_a;
    logic [7:0] acc_out, bus_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    acc_alu u_acc_alu (
        .clk(clk), .rst(rst), .bus_in(bus_in), .load_a(load_a), .load_b(load_b),
        .op_sub(op_sub), .op_add(op_add), .op_and(op_and), .op_or(op_or),
        .op_not(op_not), .drive_a(drive_a), .acc_out(acc_out), .bus_out(bus_out)
    );

    // ops field: {sub, add, and, or, not}
    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [4:0] ops;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{8'h12, 8'h34, 5'b01000, 8'h46, 4'd3},  // R3 add
        '{8'hF0, 8'h20, 5'b01000, 8'h10, 4'd3},  // R3 add wraps
        '{8'h50, 8'h20, 5'b10000, 8'h30, 4'd4},  // R4 sub
        '{8'h05, 8'h07, 5'b10000, 8'hFE, 4'd4},  // R4 sub wraps
        '{8'hCC, 8'hAA, 5'b00100, 8'h88, 4'd5},  // R5 and
        '{8'hCC, 8'hAA, 5'b00010, 8'hEE, 4'd6},  // R6 or
        '{8'h5A, 8'hFF, 5'b00001, 8'hA5, 4'd7},  // R7 not ignores B
        '{8'h10, 8'h01, 5'b11000, 8'h0F, 4'd9},  // R9 sub over add
        '{8'h0F, 8'hF1, 5'b01100, 8'h00, 4'd9},  // R9 add over and
        '{8'h3C, 8'h0F, 5'b00111, 8'h0C, 4'd9},  // R9 and over or/not
        '{8'h3C, 8'h0F, 5'b00011, 8'h3F, 4'd9}   // R9 or over not
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        load_a = 0; load_b = 0;
        {op_sub, op_add, op_and, op_or, op_not} = 5'b0;
    endtask

    // inputs set after a falling edge; result sampled at the next falling edge
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic load_ab(input logic [7:0] a, input logic [7:0] b);
        bus_in = a; load_a = 1; step();
        bus_in = b; load_b = 1; step();
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle_inputs();
        bus_in = 8'h00; drive_a = 1; rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1: A cleared, B cleared (add of loaded A returns A)
        check("R1", acc_out, 8'h00);
        check("R1", bus_out, 8'h00);
        bus_in = 8'h77; load_a = 1; step();
        check("R2", acc_out, 8'h77);
        op_add = 1; step();
        check("R1", acc_out, 8'h77);

        // vector table
        for (int i = 0; i < NV; i++) begin
            load_ab(VEC[i].a, VEC[i].b);
            {op_sub, op_add, op_and, op_or, op_not} = VEC[i].ops;
            step();
            check($sformatf("R%0d", VEC[i].req), acc_out, VEC[i].exp);
        end

        // R8: idle holds across several edges, bus_in toggled
        load_ab(8'h6B, 8'h11);
        for (int k = 0; k < 3; k++) begin
            bus_in = 8'hFF ^ 8'(k);
            step();
            check("R8", acc_out, 8'h6B);
        end

        // R10: bus drive follows enable
        drive_a = 0; #1;
        check("R10", bus_out, 8'h00);
        drive_a = 1; #1;
        check("R10", bus_out, 8'h6B);

        // R9: active op beats load_a
        load_ab(8'h10, 8'h01);
        bus_in = 8'h99; load_a = 1; op_add = 1; step();
        check("R9", acc_out, 8'h11);

        // R11: load_b concurrent with op uses old B
        load_ab(8'h10, 8'h01);
        bus_in = 8'h05; load_b = 1; op_add = 1; step();
        check("R11", acc_out, 8'h11);
        op_add = 1; step();
        check("R11", acc_out, 8'h16);

        // R1: mid-run reset clears state
        rst = 1; step(); rst = 0;
        check("R1", acc_out, 8'h00);
        bus_in = 8'h21; load_a = 1; step();
        op_or = 1; step();
        check("R1", acc_out, 8'h21);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule